// File: doc/BRIEF.md
# Dual-Converter Mono Combiner

This block takes a two-channel serial audio stream in which both channels carry the same analog signal, digitized by two separate converters. It produces one mono sample for each stereo frame. The stream arrives in I2S format on an external bit clock, word select and data line. The block acts as a receiver: it oversamples these three pins with its own system clock, so it needs no clock of its own for the audio side. It captures each channel word, pairs the left word with the right word that follows it in the same frame, halves both and combines them.

Two combining modes are available. Sum mode adds the two halves and suits converters whose inputs are driven in phase. Difference mode subtracts the right half from the left half. It suits an arrangement where one converter's analog input is inverted: the signal is recovered, and any in-phase error that both converters add is cancelled. Each result leaves the block as a registered sample with a one-cycle valid strobe.

A four-state machine controls pairing. `ST_IDLE` waits for the first bit-clock rise and loads the current word select level. `ST_SEEK` discards traffic until it sees a word select fall, which marks a frame start. `ST_LEFT` collects the left word. When word select rises (transition *left done*), it holds that word and moves to `ST_RIGHT`. `ST_RIGHT` collects the right word. When word select falls (transition *pair done*), it issues the pair, samples the mode for the new frame and returns to `ST_LEFT`.

Top module: `adc_mono_combiner`

## Requirements
- R1: After reset, `mono_valid` is 0 and `mono_sample` is 0 until the first complete pair has been combined.
- R2: Pin bits are taken on rising edges of `i2s_bck`. `i2s_ws` low marks the left slot and high marks the right slot. A word is SAMPLE_W bits, MSB first, starting at the second rising edge after a word select change. Its LSB is taken at or before the rising edge where word select next changes. Slot bits beyond SAMPLE_W are ignored.
- R3: With `mode_sel` = 0 (sum), the output is (L >>> 1) + (R >>> 1). L and R are two's complement words and >>> is an arithmetic shift, so each half is rounded toward minus infinity.
- R4: With `mode_sel` = 1 (difference), the output is (L >>> 1) - (R >>> 1). It is formed one bit wider than SAMPLE_W and then saturated to the signed SAMPLE_W range.
- R5: A left word is combined only with the right word of the same frame. A right word is never combined with the left word that follows it. The result is issued after the word select fall that ends the right slot.
- R6: Exactly one mono sample is issued per frame, and `mono_valid` is high for exactly one clock cycle for each one.
- R7: After reset, no output is produced from any traffic that comes before the first observed word select fall. That traffic includes a partial left slot and a right word with no captured left word. The first output comes from the first complete frame.
- R8: `mode_sel` is sampled only at the word select fall that starts a frame. A change in the middle of a frame first affects the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| i2s_bck | input | 1 | External serial bit clock |
| i2s_ws | input | 1 | Word select: 0 = left slot, 1 = right slot |
| i2s_sd | input | 1 | Serial data, MSB first |
| mode_sel | input | 1 | 0 = sum of halves, 1 = difference of halves |
| mono_valid | output | 1 | One-cycle strobe for a new mono sample |
| mono_sample | output | SAMPLE_W | Combined mono sample, two's complement |

## Verification
If the pairing state is wrong, the output goes wrong within one frame. A machine that pairs a right word with the next left word either issues a sample one word select edge too early, or combines values from two different frames. Both show at the first strobe as a value outside the arithmetic expectation. A lost frame-start or a stuck shift counter shifts bits within a word, which also corrupts the next strobed value. An extra or missing strobe changes the strobe count against the number of frames sent, and a premature output during start-up traffic appears before any complete frame has been sent.

// File: rtl/mono_comb_pkg.sv
package mono_comb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEEK  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } rx_state_t;

    localparam logic MODE_SUM  = 1'b0;
    localparam logic MODE_DIFF = 1'b1;

endpackage

// File: rtl/i2s_pin_sync.sv
module i2s_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_in,
    input  logic ws_in,
    input  logic sd_in,
    output logic bit_rise,
    output logic ws_bit,
    output logic sd_bit
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] bck_q;
    logic [SYNC_STAGES-1:0] ws_q;
    logic [SYNC_STAGES-1:0] sd_q;
    logic                   bck_last;

    generate
        if (SYNC_STAGES < 2) begin : g_bad_depth
            initial $error("i2s_pin_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bck_q    <= '0;
            ws_q     <= '0;
            sd_q     <= '0;
            bck_last <= 1'b0;
        end else begin
            bck_q    <= {bck_q[SYNC_STAGES-2:0], bck_in};
            ws_q     <= {ws_q[SYNC_STAGES-2:0], ws_in};
            sd_q     <= {sd_q[SYNC_STAGES-2:0], sd_in};
            bck_last <= bck_q[LAST];
        end
    end

    assign bit_rise = bck_q[LAST] & ~bck_last;
    assign ws_bit   = ws_q[LAST];
    assign sd_bit   = sd_q[LAST];

    a_r6_rise_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bit_rise |=> !bit_rise);

endmodule

// File: rtl/i2s_frame_fsm.sv
module i2s_frame_fsm
    import mono_comb_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                ws_bit,
    input  logic                sd_bit,
    input  logic                mode_sel,
    output logic [SAMPLE_W-1:0] left_hold,
    output logic [SAMPLE_W-1:0] right_word,
    output logic                pair_mode,
    output logic                pair_done
);

    localparam int CNT_W = $clog2(SAMPLE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);

    rx_state_t           state, nxt;
    logic                ws_prev;
    logic [SAMPLE_W-1:0] shreg;
    logic [SAMPLE_W-1:0] shifted;
    logic [CNT_W-1:0]    cnt;
    logic                mode_lat;
    logic                ws_edge;
    logic                frame_start;
    logic                left_done;

    assign ws_edge     = bit_rise && (ws_bit != ws_prev);
    assign frame_start = ws_edge && !ws_bit;
    assign left_done   = ws_edge && ws_bit;
    assign shifted     = (cnt < CNT_FULL) ? {shreg[SAMPLE_W-2:0], sd_bit} : shreg;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (bit_rise)    nxt = ST_SEEK;
            ST_SEEK:  if (frame_start) nxt = ST_LEFT;
            ST_LEFT:  if (left_done)   nxt = ST_RIGHT;
            ST_RIGHT: if (frame_start) nxt = ST_LEFT;
            default:                   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // slot deserializer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_prev <= 1'b0;
            shreg   <= '0;
            cnt     <= '0;
        end else if (bit_rise) begin
            ws_prev <= ws_bit;
            if (ws_edge || state == ST_IDLE) begin
                shreg <= '0;
                cnt   <= '0;
            end else begin
                shreg <= shifted;
                if (cnt < CNT_FULL) cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_hold  <= '0;
            right_word <= '0;
            pair_mode  <= MODE_SUM;
            pair_done  <= 1'b0;
            mode_lat   <= MODE_SUM;
        end else begin
            pair_done <= 1'b0;
            unique case (state)
                ST_IDLE: ;
                ST_SEEK: begin
                    if (frame_start) mode_lat <= mode_sel;
                end
                ST_LEFT: begin
                    if (left_done) left_hold <= shifted;
                end
                ST_RIGHT: begin
                    if (frame_start) begin
                        right_word <= shifted;
                        pair_mode  <= mode_lat;
                        pair_done  <= 1'b1;
                        mode_lat   <= mode_sel;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r6_one_pair_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> !pair_done);

    a_r7_no_early_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SEEK) |=> !pair_done);

    a_r8_mode_only_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode_lat));

    a_r5_pair_from_right: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |-> (state == ST_LEFT));

endmodule

// File: rtl/mono_combine.sv
module mono_combine #(
    parameter int SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                diff_mode,
    output logic [SAMPLE_W-1:0] mono_out
);

    localparam int EXT_W = SAMPLE_W + 1;
    localparam logic [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [EXT_W-1:0] half_l, half_r, raw;

    always_comb begin
        half_l = {left_in[SAMPLE_W-1],  left_in[SAMPLE_W-1],  left_in[SAMPLE_W-1:1]};
        half_r = {right_in[SAMPLE_W-1], right_in[SAMPLE_W-1], right_in[SAMPLE_W-1:1]};
        raw    = diff_mode ? (half_l - half_r) : (half_l + half_r);
        if (raw[EXT_W-1] != raw[EXT_W-2]) mono_out = raw[EXT_W-1] ? NEG_MIN : POS_MAX;
        else                              mono_out = raw[SAMPLE_W-1:0];
    end

    always_comb begin
        if (diff_mode && left_in == right_in)
            a_r4_equal_cancels: assert (mono_out == '0);
        if (!diff_mode && left_in == right_in)
            a_r3_equal_sum: assert (mono_out == {left_in[SAMPLE_W-1:1], 1'b0});
    end

endmodule

// File: rtl/adc_mono_combiner.sv
module adc_mono_combiner #(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                i2s_bck,
    input  logic                i2s_ws,
    input  logic                i2s_sd,
    input  logic                mode_sel,
    output logic                mono_valid,
    output logic [SAMPLE_W-1:0] mono_sample
);

    logic                bit_rise, ws_bit, sd_bit;
    logic [SAMPLE_W-1:0] left_hold, right_word, comb_res;
    logic                pair_mode, pair_done;

    i2s_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bck_in   (i2s_bck),
        .ws_in    (i2s_ws),
        .sd_in    (i2s_sd),
        .bit_rise (bit_rise),
        .ws_bit   (ws_bit),
        .sd_bit   (sd_bit)
    );

    i2s_frame_fsm #(.SAMPLE_W(SAMPLE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_rise   (bit_rise),
        .ws_bit     (ws_bit),
        .sd_bit     (sd_bit),
        .mode_sel   (mode_sel),
        .left_hold  (left_hold),
        .right_word (right_word),
        .pair_mode  (pair_mode),
        .pair_done  (pair_done)
    );

    mono_combine #(.SAMPLE_W(SAMPLE_W)) u_comb (
        .left_in   (left_hold),
        .right_in  (right_word),
        .diff_mode (pair_mode),
        .mono_out  (comb_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mono_valid  <= 1'b0;
            mono_sample <= '0;
        end else begin
            mono_valid <= pair_done;
            if (pair_done) mono_sample <= comb_res;
        end
    end

    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        mono_valid |=> !mono_valid);

    a_r5_valid_follows_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mono_valid |-> $past(pair_done));

    a_r1_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
        !mono_valid |=> $stable(mono_sample) || mono_valid);

endmodule

// File: tb/test_adc_mono_combiner.sv
module test_adc_mono_combiner;

    localparam int W    = 4;
    localparam int SLOT = 6;
    localparam int MAXF = 600;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         i2s_bck = 1'b0;
    logic         i2s_ws = 1'b0;
    logic         i2s_sd = 1'b0;
    logic         mode_sel = 1'b0;
    logic         mono_valid;
    logic [W-1:0] mono_sample;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_val [0:MAXF-1];
    int exp_req [0:MAXF-1];
    int wr_idx  = 0;
    int rd_idx  = 0;
    bit cur_mode = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adc_mono_combiner #(.SAMPLE_W(W), .SYNC_STAGES(2)) i_adc_mono_combiner (
        .clk         (clk),
        .rst_n       (rst_n),
        .i2s_bck     (i2s_bck),
        .i2s_ws      (i2s_ws),
        .i2s_sd      (i2s_sd),
        .mode_sel    (mode_sel),
        .mono_valid  (mono_valid),
        .mono_sample (mono_sample)
    );

    function automatic int model(input int a, input int b, input bit m);
        int r;
        r = m ? ((a >>> 1) - (b >>> 1)) : ((a >>> 1) + (b >>> 1));
        if (r > (2 ** (W - 1)) - 1) r = (2 ** (W - 1)) - 1;
        if (r < -(2 ** (W - 1)))    r = -(2 ** (W - 1));
        return r;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic send_bit(input logic w, input logic d);
        i2s_bck = 1'b0;
        i2s_ws  = w;
        i2s_sd  = d;
        #40;
        i2s_bck = 1'b1;
        #40;
    endtask

    // one slot: word MSB first, pad bits set to 1 (R2: ignored); the last bit carries the next ws level
    task automatic send_slot(input logic w, input logic nw, input int word,
                             input bit flip_mid, input bit set_next, input bit nmode);
        logic [W-1:0] bits;
        bits = W'(word);
        for (int k = 0; k < SLOT; k++) begin
            logic d;
            d = (k < W) ? bits[W-1-k] : 1'b1;
            if (flip_mid && k == 2) mode_sel = ~mode_sel;
            if (set_next && k == SLOT - 1) mode_sel = nmode;
            send_bit((k == SLOT - 1) ? nw : w, d);
        end
    endtask

    task automatic send_frame(input int a, input int b, input bit nmode, input bit flip, input int req);
        exp_val[wr_idx] = model(a, b, cur_mode);
        exp_req[wr_idx] = req;
        wr_idx++;
        send_slot(1'b0, 1'b1, a, flip, 1'b0, 1'b0);
        send_slot(1'b1, 1'b0, b, 1'b0, 1'b1, nmode);
        cur_mode = nmode;
    endtask

    // output monitor, sampled on the falling clock edge
    always @(negedge clk) begin
        if (rst_n && mono_valid) begin
            if (rd_idx >= wr_idx) begin
                check("R7 unexpected output", 1, 0);
            end else begin
                case (exp_req[rd_idx])
                    3: check("R3 sum", $signed(mono_sample), exp_val[rd_idx]);
                    4: check("R4 diff", $signed(mono_sample), exp_val[rd_idx]);
                    8: check("R8 mode change mid-frame", $signed(mono_sample), exp_val[rd_idx]);
                    default: check("R5 pairing", $signed(mono_sample), exp_val[rd_idx]);
                endcase
            end
            rd_idx++;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int start_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset valid", int'(mono_valid), 0);
        check("R1 reset sample", int'(mono_sample), 0);

        // R7: partial left slot, then an orphan right word
        for (int k = 0; k < 3; k++) send_bit(1'b0, 1'b1);
        cur_mode = 1'b0;
        mode_sel = 1'b0;
        send_slot(1'b0, 1'b1, 5, 1'b0, 1'b0, 1'b0);
        send_slot(1'b1, 1'b0, 6, 1'b0, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        check("R7 no output from start-up traffic", rd_idx, 0);

        // R3/R4/R2: full sweep of both modes and all word pairs
        for (int i = 0; i < 512; i++) begin
            int a, b;
            bit m, nm;
            m  = bit'(i / 256);
            nm = bit'(((i + 1) / 256) % 2);
            a  = ((i / 16) % 16) - 8;
            b  = (i % 16) - 8;
            send_frame(a, b, nm, 1'b0, m ? 4 : 3);
        end

        // R8: mode toggled in the middle of the left slot
        send_frame(7, -8, 1'b1, 1'b1, 8);
        send_frame(7, -8, 1'b0, 1'b1, 8);
        send_frame(-8, 7, 1'b1, 1'b1, 8);
        send_frame(-8, 7, 1'b1, 1'b0, 8);

        // R5: distinct left/right values, each left paired with its own right
        send_frame(3, -3, 1'b0, 1'b0, 5);
        send_frame(-5, 1, 1'b0, 1'b0, 5);
        send_frame(6, 2, 1'b0, 1'b0, 5);

        start_cnt = wr_idx;
        for (int k = 0; k < 3; k++) send_bit(1'b0, 1'b0);
        repeat (10) @(negedge clk);
        check("R6 one output per frame", rd_idx, start_cnt);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule